// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

The block turns one stereo sample pair per frame into a serial bit stream on a single data pin. It does not make its own audio clocks. It runs on a fast system clock and synchronises an external bit clock and frame clock, then acts on the bit-clock edges it detects. It supports four framings: left-justified, I2S, right-justified and a short-pulse DSP framing. In the DSP framing the MSB can appear at one of two positions. Each output channel picks either the left or the right input sample, so channels can be swapped or duplicated.

A two-slot time-division option lets a second transmitter share the data line. In that mode the output-enable is high only while this block's slot is on the line.

Once per frame, at the launch edge that opens the frame, the block captures the input sample words and pulses a one-cycle sample request. The source then presents the next pair.

Top module: `audtx_top`

## Requirements
- R1: Format code `fmt_i` selects 00 = right-justified, 01 = left-justified, 10 = I2S and 11 = DSP. In left-justified, the MSB is driven in bit period 0, meaning the bit period launched at the same bit-clock edge where the frame-clock change is seen. In I2S, the MSB is driven in bit period 1.
- R2: In right-justified framing, the LSB falls in the last bit period before the next frame-clock change. The half length used for this is the one measured over the previous half.
- R3: `wlen_i` selects the word length W: 00 = 16, 01 = 20, 10 = 24, 11 = 32 bits. Sample inputs are MSB-aligned, so the word is bits [31:32-W]. Every bit period outside the word drives 0, and the data pin is 0 whenever output-enable is low.
- R4: Output channel 0 (left) carries the right input when `lsel_i` = 1, else the left input. Output channel 1 carries the right input when `rsel_i` = 1, else the left input.
- R5: In the non-DSP framings the left half is the one where the frame clock XOR `fpol_mode_i` is 0, so setting `fpol_mode_i` swaps the halves.
- R6: In DSP framing a frame starts at a frame-clock rise. The left word's MSB is in bit period 1 when `fpol_mode_i` = 0 (mode A) and in bit period 0 when it is 1 (mode B). The right word follows the left word with no gap.
- R7: With `bclk_inv_i` = 0, data launches on falling bit-clock edges. With `bclk_inv_i` = 1, it launches on rising edges, and the resulting frame is the same.
- R8: With `tdm_en_i` = 0, the output-enable is high after every launch. With `tdm_en_i` = 1, the enable is high only inside the selected slot. In DSP, slot 0 covers data positions 0..2W-1 and slot 1 the next 2W. In the other framings each half holds slot 0 (W positions) followed by slot 1 (W positions), and in right-justified the pair of slots ends at the half's end. `tdm_slot_i` = 1 selects slot 1.
- R9: `sample_req_o` is a one-system-cycle pulse at the launch that opens each frame (left-half start, or DSP frame-clock rise). The input words are captured in that same cycle.
- R10: While reset is applied, `sdata_o`, `sdata_oe_o` and `sample_req_o` are 0.
- R11: `sdata_o` and `sdata_oe_o` change only after a detected launch edge and hold between launches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | External bit clock |
| fclk_i | input | 1 | External frame clock |
| left_i | input | 32 | Left sample word, MSB-aligned |
| right_i | input | 32 | Right sample word, MSB-aligned |
| fmt_i | input | 2 | Framing format code |
| wlen_i | input | 2 | Word length code |
| lsel_i | input | 1 | Source select for output channel 0 |
| rsel_i | input | 1 | Source select for output channel 1 |
| fpol_mode_i | input | 1 | Frame-clock polarity, or DSP MSB timing in DSP framing |
| bclk_inv_i | input | 1 | Bit-clock edge invert |
| tdm_en_i | input | 1 | Time-division enable |
| tdm_slot_i | input | 1 | Time-division slot select |
| sdata_o | output | 1 | Serial data |
| sdata_oe_o | output | 1 | Serial data output-enable |
| sample_req_o | output | 1 | One-cycle request for the next sample pair |

## Verification
The bench runs a separate sample pair on every frame, with left and right words that differ in every byte. Exercising the framing formats at each word length separates the MSB offset of left-justified, I2S and the two DSP timings from the end alignment of right-justified. Swapped and duplicated routing shows whether each channel picks its own source. Inverting the frame polarity and the bit clock must produce the same decoded stream at the other phase and edge. Runs with time-division enabled, in both slots, check where the output-enable window opens and closes and that the line is quiet outside it.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } audtx_fmt_e;

  function automatic logic [5:0] wlen_bits(input logic [1:0] code);
    logic [5:0] w;
    case (code)
      2'b00:   w = 6'd16;
      2'b01:   w = 6'd20;
      2'b10:   w = 6'd24;
      default: w = 6'd32;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/audtx_sync.sv
module audtx_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], din[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign dout[i] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/audtx_edge.sv
module audtx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic inv_i,
  output logic launch_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  // launch on the falling edge of the effective (possibly inverted) clock
  assign launch_o = (prev_q ^ inv_i) & ~(lvl_i ^ inv_i);

endmodule

// File: rtl/audtx_slot_map.sv
module audtx_slot_map
  import audtx_pkg::*;
#(
  parameter int CW = 8,
  parameter int SW = 32
) (
  input  audtx_fmt_e    fmt_i,
  input  logic          mode_b_i,
  input  logic [1:0]    wlen_i,
  input  logic          tdm_en_i,
  input  logic          tdm_slot_i,
  input  logic [CW-1:0] k_i,
  input  logic [CW:0]   len_i,
  input  logic          right_half_i,
  input  logic [SW-1:0] w0_i,
  input  logic [SW-1:0] w1_i,
  output logic          bit_o,
  output logic          in_slot_o
);

  localparam int DW = CW + 4;

  logic signed [DW-1:0] wd, span, base, kd, ld, d, idx;
  logic                 is_dsp, pick_w1;
  logic [SW-1:0]        word, shifted;

  always_comb begin
    is_dsp = (fmt_i == FMT_DSP);
    wd     = $signed(DW'(wlen_bits(wlen_i)));
    kd     = $signed(DW'(k_i));
    ld     = $signed(DW'(len_i));
    span   = is_dsp ? (wd <<< 1) : wd;
    case (fmt_i)
      FMT_LJ:  base = '0;
      FMT_I2S: base = DW'(1);
      FMT_RJ:  base = ld - (tdm_en_i ? (wd <<< 1) : wd);
      default: base = mode_b_i ? '0 : DW'(1);
    endcase
    d         = kd - base - ((tdm_en_i && tdm_slot_i) ? span : '0);
    in_slot_o = (d >= 0) && (d < span);
    pick_w1   = is_dsp ? (d >= wd) : right_half_i;
    idx       = (is_dsp && (d >= wd)) ? (d - wd) : d;
    word      = pick_w1 ? w1_i : w0_i;
    shifted   = word << idx;
    bit_o     = in_slot_o & shifted[SW-1];
  end

endmodule

// File: rtl/audtx_top.sv
module audtx_top
  import audtx_pkg::*;
#(
  parameter int CW          = 8,
  parameter int SW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_i,
  input  logic          fclk_i,
  input  logic [SW-1:0] left_i,
  input  logic [SW-1:0] right_i,
  input  logic [1:0]    fmt_i,
  input  logic [1:0]    wlen_i,
  input  logic          lsel_i,
  input  logic          rsel_i,
  input  logic          fpol_mode_i,
  input  logic          bclk_inv_i,
  input  logic          tdm_en_i,
  input  logic          tdm_slot_i,
  output logic          sdata_o,
  output logic          sdata_oe_o,
  output logic          sample_req_o
);

  localparam logic [CW-1:0] K_MAX = '1;

  // reset: asserted asynchronously, released on clk
  logic [1:0] rst_sync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic [1:0] sync_out;
  logic       bclk_s, fclk_s, launch;

  audtx_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_q),
    .din  ({fclk_i, bclk_i}),
    .dout (sync_out)
  );
  assign bclk_s = sync_out[0];
  assign fclk_s = sync_out[1];

  audtx_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_q),
    .lvl_i   (bclk_s),
    .inv_i   (bclk_inv_i),
    .launch_o(launch)
  );

  audtx_fmt_e    fmt;
  logic          fr_last_q, half_q, sd_q, oe_q, req_q;
  logic [CW-1:0] k_q, k_d;
  logic [CW:0]   len_q, len_d;
  logic [SW-1:0] hold_l_q, hold_r_q, src_l, src_r, w0, w1;
  logic          is_dsp, pol, chg, start, restart, half_d, bit_d, in_slot, oe_d;

  always_comb begin
    fmt     = audtx_fmt_e'(fmt_i);
    is_dsp  = (fmt == FMT_DSP);
    pol     = fclk_s ^ (~is_dsp & fpol_mode_i);
    chg     = (fclk_s != fr_last_q);
    start   = is_dsp ? (fclk_s & ~fr_last_q) : (chg & ~pol);
    restart = is_dsp ? start : chg;
    if (restart)          k_d = '0;
    else if (k_q == K_MAX) k_d = k_q;
    else                  k_d = k_q + 1'b1;
    len_d   = chg ? ({1'b0, k_q} + 1'b1) : len_q;
    half_d  = ~is_dsp & pol;
    src_l   = start ? left_i  : hold_l_q;
    src_r   = start ? right_i : hold_r_q;
    w0      = lsel_i ? src_r : src_l;
    w1      = rsel_i ? src_r : src_l;
    oe_d    = tdm_en_i ? in_slot : 1'b1;
  end

  audtx_slot_map #(.CW(CW), .SW(SW)) u_map (
    .fmt_i       (fmt),
    .mode_b_i    (fpol_mode_i),
    .wlen_i      (wlen_i),
    .tdm_en_i    (tdm_en_i),
    .tdm_slot_i  (tdm_slot_i),
    .k_i         (k_d),
    .len_i       (len_d),
    .right_half_i(half_d),
    .w0_i        (w0),
    .w1_i        (w1),
    .bit_o       (bit_d),
    .in_slot_o   (in_slot)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      fr_last_q <= 1'b0;
      k_q       <= '0;
      len_q     <= '0;
      half_q    <= 1'b0;
      hold_l_q  <= '0;
      hold_r_q  <= '0;
      sd_q      <= 1'b0;
      oe_q      <= 1'b0;
      req_q     <= 1'b0;
    end else begin
      req_q <= launch & start;
      if (launch) begin
        fr_last_q <= fclk_s;
        k_q       <= k_d;
        len_q     <= len_d;
        half_q    <= half_d;
        sd_q      <= bit_d & oe_d;
        oe_q      <= oe_d;
        if (start) begin
          hold_l_q <= left_i;
          hold_r_q <= right_i;
        end
      end
    end
  end

  assign sdata_o      = sd_q;
  assign sdata_oe_o   = oe_q;
  assign sample_req_o = req_q;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_q)
    req_q |=> !req_q); // R9
  AST_REQ_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rst_q)
    req_q |-> (k_q == '0)); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    !launch |=> ($stable(sd_q) && $stable(oe_q))); // R11
  AST_OE_FULL: assert property (@(posedge clk) disable iff (!rst_q)
    (launch && !tdm_en_i) |=> oe_q); // R8
  AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_q)
    !oe_q |-> !sd_q); // R3
  AST_HALF_DSP: assert property (@(posedge clk) disable iff (!rst_q)
    (launch && is_dsp) |=> !half_q); // R6

endmodule

// File: tb/test_audtx_top.sv
module test_audtx_top;

  localparam int H = 34;   // bit periods per half (non-DSP)
  localparam int F = 130;  // bit periods per frame (DSP)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b1, fclk = 1'b0;
  logic [31:0] left_w, right_w;
  logic [1:0]  fmt = 2'b10, wlen = 2'b10;
  logic        lsel = 1'b0, rsel = 1'b1, pm = 1'b0, binv = 1'b0, tdm = 1'b0, slot = 1'b0;
  logic        sdata, sdata_oe, sample_req;

  int vectors = 0, miscompares = 0, req_cnt = 0, cfg_id = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  audtx_top i_audtx_top (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fclk_i(fclk),
    .left_i(left_w), .right_i(right_w), .fmt_i(fmt), .wlen_i(wlen),
    .lsel_i(lsel), .rsel_i(rsel), .fpol_mode_i(pm), .bclk_inv_i(binv),
    .tdm_en_i(tdm), .tdm_slot_i(slot),
    .sdata_o(sdata), .sdata_oe_o(sdata_oe), .sample_req_o(sample_req)
  );

  function automatic logic [31:0] pat_l(int id, int n);
    return 32'hC3A5_1E96 ^ (32'(n) * 32'h1357_9BDF) ^ (32'(id) * 32'h0F0F_1234);
  endfunction

  function automatic logic [31:0] pat_r(int id, int n);
    logic [31:0] x;
    x = pat_l(id, n);
    return {x[15:0], x[31:16]} ^ 32'h5AA5_C33C;
  endfunction

  assign left_w  = pat_l(cfg_id, req_cnt);
  assign right_w = pat_r(cfg_id, req_cnt);

  always @(negedge clk) begin
    if (!rst_n) req_cnt <= 0;
    else if (sample_req) req_cnt <= req_cnt + 1;
  end

  // expected {oe, data} for bit period k, from the requirements
  function automatic logic [1:0] expect_out(int k, int half, logic [31:0] l, logic [31:0] r);
    int w, d, base, span;
    logic [31:0] c0, c1, word;
    logic in, b;
    case (wlen)
      2'b00: w = 16;
      2'b01: w = 20;
      2'b10: w = 24;
      default: w = 32;
    endcase
    c0 = lsel ? r : l;
    c1 = rsel ? r : l;
    if (fmt == 2'b11) begin
      span = 2 * w;
      base = pm ? 0 : 1;
    end else begin
      span = w;
      if (fmt == 2'b01)      base = 0;
      else if (fmt == 2'b10) base = 1;
      else                   base = H - w * (tdm ? 2 : 1);
    end
    d  = k - base - ((tdm && slot) ? span : 0);
    in = (d >= 0) && (d < span);
    if (fmt == 2'b11) word = (d >= w) ? c1 : c0;
    else              word = half ? c1 : c0;
    if (fmt == 2'b11 && d >= w) d = d - w;
    b = in ? word[31 - d] : 1'b0;
    return {tdm ? in : 1'b1, b};
  endfunction

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s cfg %0d: {oe,data} actual=%b expected=%b at %0t", tag, cfg_id, act, exp, $time);
    end
  endtask

  task automatic bit_period(logic lv, bit check, string tag, logic [1:0] e);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      if (c == 0) begin
        bclk = 1'b0 ^ binv;
        fclk = lv;
      end
      if (c == 8) bclk = 1'b1 ^ binv;
      if (check && c >= 4) chk((c == 4) ? tag : "R11", {sdata_oe, sdata}, e);
    end
  endtask

  task automatic run_cfg(int id, string tag, logic [1:0] f, logic [1:0] wl, logic ls, logic rs,
                         logic p, logic bi, logic te, logic ts);
    logic left_lv;
    rst_n = 1'b0;
    cfg_id = id; fmt = f; wlen = wl; lsel = ls; rsel = rs; pm = p; binv = bi; tdm = te; slot = ts;
    left_lv = (f == 2'b11) ? 1'b1 : p;
    bclk = 1'b1 ^ bi;
    fclk = (f == 2'b11) ? 1'b0 : ~left_lv;
    repeat (3) @(negedge clk);
    if (id == 0) begin
      chk("R10", {sdata_oe, sdata}, 2'b00);
      chk("R10", {1'b0, sample_req}, 2'b00);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) bit_period((f == 2'b11) ? 1'b0 : ~left_lv, 1'b0, tag, 2'b00);
    for (int fr = 0; fr < 3; fr++) begin
      if (f == 2'b11) begin
        for (int k = 0; k < F; k++)
          bit_period(k == 0, fr > 0, tag, expect_out(k, 0, pat_l(id, fr), pat_r(id, fr)));
      end else begin
        for (int h = 0; h < 2; h++)
          for (int k = 0; k < H; k++)
            bit_period(h ? ~left_lv : left_lv, fr > 0, tag,
                       expect_out(k, h, pat_l(id, fr), pat_r(id, fr)));
      end
    end
    vectors++;
    if (req_cnt != 3) begin
      miscompares++;
      $display("FAIL R9 cfg %0d: requests actual=%0d expected=3", id, req_cnt);
    end
  endtask

  initial begin
    //        id tag    fmt    wlen  ls    rs    pm    binv  tdm   slot
    run_cfg( 0, "R1", 2'b01, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_cfg( 1, "R1", 2'b10, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_cfg( 2, "R2", 2'b00, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_cfg( 3, "R3", 2'b01, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_cfg( 4, "R3", 2'b10, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_cfg( 5, "R3", 2'b00, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_cfg( 6, "R4", 2'b10, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_cfg( 7, "R4", 2'b01, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_cfg( 8, "R5", 2'b10, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    run_cfg( 9, "R7", 2'b01, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    run_cfg(10, "R8", 2'b10, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    run_cfg(11, "R8", 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    run_cfg(12, "R6", 2'b11, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_cfg(13, "R6", 2'b11, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    run_cfg(14, "R8", 2'b11, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    run_cfg(15, "R7", 2'b11, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule